// File: doc/BRIEF.md
# Counter Enable Register Access-Control Unit

This block keeps the run/stop enables for five activity-monitor event counters. It presents them as one 32-bit system register with set-only write semantics: a 1 in a low bit of the write data turns that counter on, and a 0 leaves it as it was. Bits above the counter count always read as zero. A separate debug read port can observe the same enables at a fixed offset but has no way to write them.

Every system-register request carries the requester's privilege level (0 to 3) and a non-secure flag. The unit judges each request against three configuration enables, one per level from 1 to 3. It either services the request, reports a trap together with the level that must handle it, or flags an undefined write when a lower level tries to modify the register. All request results appear on a registered response one cycle after the request. The enable outputs connect directly to the counters.

Top module: `cnten_ctl`

## Requirements
- R1: A synchronous reset clears all five enables, `rsp_valid`, `rsp_trap`, `rsp_trap_el`, `rsp_undef`, `rsp_rdata`, `dbg_rvalid` and `dbg_rdata`.
- R2: A non-trapped write from level 3 sets every enable whose bit in `req_wdata[4:0]` is 1, at the clock edge that samples the request. Bits written as 0 keep their value, and no system-register access ever clears an enable.
- R3: A non-trapped read from any level returns the enables in `rsp_rdata[4:0]` one cycle after the request. The returned value is the state before that edge.
- R4: Write data in bits 31 to 5 is ignored, and bits 31 to 5 of every read result are zero.
- R5: A level-0 request while `cfg_usr_en` is 0 traps: `rsp_trap`=1 and `rsp_trap_el`=1. This holds whatever the other two enables are.
- R6: Otherwise, a non-secure (`req_ns`=1) request from level 0 or 1 while `cfg_el2_en` is 0 traps with `rsp_trap_el`=2.
- R7: Otherwise, a request from levels 0 to 2 while `cfg_el3_en` is 0 traps with `rsp_trap_el`=3. Level-3 requests never trap. `rsp_trap_el` is 0 whenever `rsp_trap` is 0.
- R8: A trapped request leaves the enables unchanged and returns `rsp_rdata`=0.
- R9: A non-trapped write from levels 0 to 2 raises `rsp_undef` for the response cycle. It leaves the enables unchanged and returns `rsp_rdata`=0.
- R10: A debug read at address 0xC00 raises `dbg_rvalid` one cycle later, with the pre-edge enables in `dbg_rdata[4:0]`. Any other address gives `dbg_rvalid`=0 and `dbg_rdata`=0.
- R11: `ctr_en[n]` is the enable of counter n and matches bit n of a non-trapped read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | System-register request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lvl | input | 2 | Requester privilege level 0..3 |
| req_ns | input | 1 | Requester is non-secure |
| req_wdata | input | 32 | Write data |
| cfg_usr_en | input | 1 | Level-0 access enable (0 traps to level 1) |
| cfg_el2_en | input | 1 | Level-2 control enable (0 traps non-secure levels 0/1 to level 2) |
| cfg_el3_en | input | 1 | Level-3 control enable (0 traps levels 0..2 to level 3) |
| dbg_rd | input | 1 | Debug read strobe |
| dbg_addr | input | 12 | Debug read address |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 32 | Read result |
| rsp_trap | output | 1 | Request was trapped |
| rsp_trap_el | output | 2 | Level the trap is routed to |
| rsp_undef | output | 1 | Write refused as undefined |
| dbg_rvalid | output | 1 | Debug read hit the register |
| dbg_rdata | output | 32 | Debug read result |
| ctr_en | output | 5 | Enables to counters 0..4 |

## Verification
Two functions can land in the same cycle here: a debug read and a level-3 set. When both are issued together, the debug port must return the enables from before the set, while `ctr_en` shows the set value after the edge. The directed sequence forces this collision, and the random phase produces it again many times. Every cycle, the bench model predicts both ports from one shared pre-edge state and compares them. A second overlap is several trap conditions holding at once. These stacked cases are judged by the reported target level, which must be the lowest one.

// File: rtl/cnten_pkg.sv
package cnten_pkg;

  typedef enum logic [1:0] {
    LVL0 = 2'd0,
    LVL1 = 2'd1,
    LVL2 = 2'd2,
    LVL3 = 2'd3
  } lvl_e;

  typedef struct packed {
    logic trap;
    lvl_e tgt;
    logic wr_ok;
    logic rd_ok;
    logic undef;
  } verdict_t;

  // Trap routing: the lowest handling level wins; level 3 is never trapped.
  function automatic verdict_t judge(input logic is_wr, input lvl_e lvl,
                                     input logic nsec, input logic usr_on,
                                     input logic l2_on, input logic l3_on);
    verdict_t v;
    v = '0;
    if (lvl == LVL0 && !usr_on) begin
      v.trap = 1'b1;
      v.tgt  = LVL1;
    end else if ((lvl == LVL0 || lvl == LVL1) && nsec && !l2_on) begin
      v.trap = 1'b1;
      v.tgt  = LVL2;
    end else if (lvl != LVL3 && !l3_on) begin
      v.trap = 1'b1;
      v.tgt  = LVL3;
    end
    if (!v.trap) begin
      if (is_wr) begin
        v.wr_ok = (lvl == LVL3);
        v.undef = (lvl != LVL3);
      end else begin
        v.rd_ok = 1'b1;
      end
    end
    return v;
  endfunction

endpackage

// File: rtl/cnten_gate.sv
module cnten_gate
  import cnten_pkg::*;
(
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [1:0] req_lvl,
  input  logic       req_ns,
  input  logic       cfg_usr_en,
  input  logic       cfg_el2_en,
  input  logic       cfg_el3_en,
  output verdict_t   vd
);

  verdict_t raw;

  always_comb begin
    raw = judge(req_write, lvl_e'(req_lvl), req_ns,
                cfg_usr_en, cfg_el2_en, cfg_el3_en);
    vd  = req_valid ? raw : '0;
  end

endmodule

// File: rtl/cnten_bank.sv
module cnten_bank #(
  parameter int unsigned NUM_CTR = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               set_go,
  input  logic [NUM_CTR-1:0] set_bits,
  output logic [NUM_CTR-1:0] en
);

  logic [NUM_CTR-1:0] en_q;
  logic [NUM_CTR-1:0] en_nxt;

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_bit
    assign en_nxt[i] = en_q[i] | (set_go & set_bits[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else     en_q <= en_nxt;
  end

  assign en = en_q;

endmodule

// File: rtl/cnten_dbg.sv
module cnten_dbg #(
  parameter int unsigned NUM_CTR = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] OFFS = 12'hC00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               dbg_rd,
  input  logic [ADDR_W-1:0]  dbg_addr,
  input  logic [NUM_CTR-1:0] en,
  output logic               dbg_rvalid,
  output logic [DATA_W-1:0]  dbg_rdata
);

  logic hit;
  assign hit = dbg_rd && (dbg_addr == OFFS);

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_rvalid <= 1'b0;
      dbg_rdata  <= '0;
    end else begin
      dbg_rvalid <= hit;
      dbg_rdata  <= hit ? DATA_W'(en) : '0;
    end
  end

endmodule

// File: rtl/cnten_ctl.sv
module cnten_ctl
  import cnten_pkg::*;
#(
  parameter int unsigned NUM_CTR = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DBG_OFFS = 12'hC00
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [1:0]         req_lvl,
  input  logic               req_ns,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic               cfg_usr_en,
  input  logic               cfg_el2_en,
  input  logic               cfg_el3_en,
  input  logic               dbg_rd,
  input  logic [ADDR_W-1:0]  dbg_addr,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               rsp_trap,
  output logic [1:0]         rsp_trap_el,
  output logic               rsp_undef,
  output logic               dbg_rvalid,
  output logic [DATA_W-1:0]  dbg_rdata,
  output logic [NUM_CTR-1:0] ctr_en
);

  verdict_t           vd;
  logic               set_go;
  logic               rd_go;
  logic               trap_now;
  logic               undef_now;
  logic               resv_wr;
  logic [NUM_CTR-1:0] wr_low;

  cnten_gate u_gate (
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_lvl    (req_lvl),
    .req_ns     (req_ns),
    .cfg_usr_en (cfg_usr_en),
    .cfg_el2_en (cfg_el2_en),
    .cfg_el3_en (cfg_el3_en),
    .vd         (vd)
  );

  // named internal events for the checker
  assign set_go    = vd.wr_ok;
  assign rd_go     = vd.rd_ok;
  assign trap_now  = vd.trap;
  assign undef_now = vd.undef;
  assign wr_low    = req_wdata[NUM_CTR-1:0];
  assign resv_wr   = |req_wdata[DATA_W-1:NUM_CTR];

  cnten_bank #(.NUM_CTR(NUM_CTR)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_go   (set_go),
    .set_bits (wr_low),
    .en       (ctr_en)
  );

  cnten_dbg #(
    .NUM_CTR (NUM_CTR),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W),
    .OFFS    (DBG_OFFS)
  ) u_dbg (
    .clk        (clk),
    .rst        (rst),
    .dbg_rd     (dbg_rd),
    .dbg_addr   (dbg_addr),
    .en         (ctr_en),
    .dbg_rvalid (dbg_rvalid),
    .dbg_rdata  (dbg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_rdata   <= '0;
      rsp_trap    <= 1'b0;
      rsp_trap_el <= 2'd0;
      rsp_undef   <= 1'b0;
    end else begin
      rsp_valid   <= req_valid;
      rsp_rdata   <= rd_go ? DATA_W'(ctr_en) : '0;
      rsp_trap    <= trap_now;
      rsp_trap_el <= vd.tgt;
      rsp_undef   <= undef_now;
    end
  end

endmodule

// File: rtl/cnten_ctl_chk.sv
module cnten_ctl_chk #(
  parameter int unsigned NUM_CTR = 5,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] DBG_OFFS = 12'hC00
) (
  input logic               clk,
  input logic               rst,
  input logic               req_valid,
  input logic [1:0]         req_lvl,
  input logic               req_ns,
  input logic               cfg_usr_en,
  input logic               cfg_el2_en,
  input logic               cfg_el3_en,
  input logic               dbg_rd,
  input logic [ADDR_W-1:0]  dbg_addr,
  input logic               rsp_valid,
  input logic [DATA_W-1:0]  rsp_rdata,
  input logic               rsp_trap,
  input logic [1:0]         rsp_trap_el,
  input logic               rsp_undef,
  input logic               dbg_rvalid,
  input logic [DATA_W-1:0]  dbg_rdata,
  input logic [NUM_CTR-1:0] ctr_en,
  input logic               set_go,
  input logic               trap_now,
  input logic               undef_now,
  input logic               resv_wr,
  input logic [NUM_CTR-1:0] wr_low
);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (ctr_en == '0 && !rsp_valid && !dbg_rvalid));

  // R2
  set_or_chk: assert property (@(posedge clk) disable iff (rst)
    set_go |=> ctr_en == ($past(ctr_en) | $past(wr_low)));

  // R2
  never_clear_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (($past(ctr_en) & ~ctr_en) == '0));

  // R4
  resv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (resv_wr && !set_go) |=> $stable(ctr_en));

  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_rdata[DATA_W-1:NUM_CTR] == '0);

  // R5
  usr_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lvl == 2'd0 && !cfg_usr_en) |=> (rsp_trap && rsp_trap_el == 2'd1));

  // R6
  l2_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lvl == 2'd1 && req_ns && !cfg_el2_en) |=> (rsp_trap && rsp_trap_el == 2'd2));

  // R7
  l3_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lvl == 2'd2 && !cfg_el3_en) |=> (rsp_trap && rsp_trap_el == 2'd3));

  // R7
  top_never_trap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_lvl == 2'd3) |=> !rsp_trap);

  // R8
  trap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    trap_now |=> ($stable(ctr_en) && rsp_rdata == '0 && !rsp_undef));

  // R9
  undef_flag_chk: assert property (@(posedge clk) disable iff (rst)
    undef_now |=> (rsp_undef && !rsp_trap && $stable(ctr_en) && rsp_rdata == '0));

  // R10
  dbg_read_chk: assert property (@(posedge clk) disable iff (rst)
    (dbg_rd && dbg_addr == DBG_OFFS) |=> (dbg_rvalid && dbg_rdata[NUM_CTR-1:0] == $past(ctr_en)));

  // R10
  dbg_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !dbg_rvalid |-> dbg_rdata == '0);

endmodule

bind cnten_ctl cnten_ctl_chk #(
  .NUM_CTR  (NUM_CTR),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W),
  .DBG_OFFS (DBG_OFFS)
) u_chk (.*);

// File: tb/sim_cnten_ctl.sv
module sim_cnten_ctl;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, req_ns;
  logic [1:0]  req_lvl;
  logic [31:0] req_wdata;
  logic        cfg_usr_en, cfg_el2_en, cfg_el3_en;
  logic        dbg_rd;
  logic [11:0] dbg_addr;
  logic        rsp_valid, rsp_trap, rsp_undef, dbg_rvalid;
  logic [31:0] rsp_rdata, dbg_rdata;
  logic [1:0]  rsp_trap_el;
  logic [4:0]  ctr_en;

  int errors = 0;
  int checks = 0;
  int model_en = 0;

  always #4 clk = ~clk;

  cnten_ctl u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_lvl(req_lvl), .req_ns(req_ns), .req_wdata(req_wdata),
    .cfg_usr_en(cfg_usr_en), .cfg_el2_en(cfg_el2_en), .cfg_el3_en(cfg_el3_en),
    .dbg_rd(dbg_rd), .dbg_addr(dbg_addr), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_trap(rsp_trap), .rsp_trap_el(rsp_trap_el),
    .rsp_undef(rsp_undef), .dbg_rvalid(dbg_rvalid), .dbg_rdata(dbg_rdata),
    .ctr_en(ctr_en)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endtask

  // One request cycle: drive at negedge, predict, sample at next negedge.
  task automatic step(input bit v, input bit w, input int lvl, input bit ns,
                      input logic [31:0] wd, input bit usr, input bit e2,
                      input bit e3, input bit drd, input logic [11:0] da);
    int tgt, nxt, exp_rd, exp_dbg;
    bit wr_ok, undef, rd_ok, hit;
    req_valid = v; req_write = w; req_lvl = 2'(lvl); req_ns = ns;
    req_wdata = wd; cfg_usr_en = usr; cfg_el2_en = e2; cfg_el3_en = e3;
    dbg_rd = drd; dbg_addr = da;
    tgt = 0;
    if (lvl == 0 && !usr)                 tgt = 1;
    else if (lvl < 2 && ns && !e2)        tgt = 2;
    else if (lvl < 3 && !e3)              tgt = 3;
    if (!v) tgt = 0;
    wr_ok  = v && w && tgt == 0 && lvl == 3;
    undef  = v && w && tgt == 0 && lvl != 3;
    rd_ok  = v && !w && tgt == 0;
    hit    = drd && da == 12'hC00;
    exp_rd = rd_ok ? model_en : 0;
    exp_dbg = hit ? model_en : 0;
    nxt    = wr_ok ? (model_en | (wd & 32'h1F)) : model_en;
    @(posedge clk);
    @(negedge clk);
    chk("R3", "rsp_valid", 32'(rsp_valid), 32'(v));
    chk(tgt != 0 ? "R8" : "R3", "rsp_rdata", rsp_rdata, 32'(exp_rd));
    chk(tgt == 1 ? "R5" : (tgt == 2 ? "R6" : "R7"), "rsp_trap", 32'(rsp_trap), 32'(tgt != 0));
    chk(tgt == 1 ? "R5" : (tgt == 2 ? "R6" : "R7"), "rsp_trap_el", 32'(rsp_trap_el), 32'(tgt));
    chk("R9", "rsp_undef", 32'(rsp_undef), 32'(undef));
    chk(tgt != 0 ? "R8" : (undef ? "R9" : "R2"), "ctr_en", 32'(ctr_en), 32'(nxt));
    chk("R10", "dbg_rvalid", 32'(dbg_rvalid), 32'(hit));
    chk("R10", "dbg_rdata", dbg_rdata, 32'(exp_dbg));
    if (rd_ok) chk("R11", "ctr_en vs read", 32'(ctr_en), rsp_rdata);
    model_en = nxt;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_en = 0;
    chk("R1", "ctr_en", 32'(ctr_en), 0);
    chk("R1", "rsp_valid", 32'(rsp_valid), 0);
    chk("R1", "rsp_trap", 32'(rsp_trap), 0);
    chk("R1", "rsp_undef", 32'(rsp_undef), 0);
    chk("R1", "dbg_rvalid", 32'(dbg_rvalid), 0);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_lvl = 0; req_ns = 0; req_wdata = 0;
    cfg_usr_en = 1; cfg_el2_en = 1; cfg_el3_en = 1; dbg_rd = 0; dbg_addr = 0;
    @(negedge clk);
    do_reset();
    // R3 read at level 3 after reset
    step(1, 0, 3, 0, 0, 1, 1, 1, 0, 0);
    // R2 set bits 0 and 2, then a zero write
    step(1, 1, 3, 0, 32'h5, 1, 1, 1, 0, 0);
    step(1, 1, 3, 0, 32'h0, 1, 1, 1, 0, 0);
    // R4 upper bits only
    step(1, 1, 3, 1, 32'hFFFF_FFE0, 1, 1, 1, 0, 0);
    step(1, 0, 3, 0, 0, 1, 1, 1, 0, 0);
    // R3 lower-level read, R9 lower-level write
    step(1, 0, 1, 1, 0, 1, 1, 1, 0, 0);
    step(1, 1, 1, 0, 32'h2, 1, 1, 1, 0, 0);
    step(1, 1, 2, 1, 32'h1F, 1, 1, 1, 0, 0);
    // R5 all three conditions at once: level 1 target wins
    step(1, 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // R6 level 2 beats level 3
    step(1, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    // R6 secure side skips the level-2 rule
    step(1, 0, 1, 0, 0, 0, 0, 1, 0, 0);
    // R7 level 2 requester with level-3 enable off
    step(1, 0, 2, 1, 0, 0, 0, 0, 0, 0);
    // R7 level 3 never traps
    step(1, 1, 3, 1, 32'h10, 0, 0, 0, 0, 0);
    // R8 trapped write leaves state
    step(1, 1, 0, 0, 32'h2, 1, 1, 0, 0, 0);
    // R10 debug reads hit and miss
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 12'hC00);
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 12'hC04);
    // R10 debug read together with a set
    step(1, 1, 3, 0, 32'h8, 1, 1, 1, 1, 12'hC00);
    step(0, 0, 0, 0, 0, 1, 1, 1, 1, 12'hC00);
    // random phase; reset now and then so sets keep happening
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (i % 150 == 149) do_reset();
      step(r[0], r[1], int'(r[3:2]), r[4],
           (r[5] ? (32'(1) << r[10:8]) : $urandom),
           r[11] | r[12], r[13] | r[14], r[15] | r[16],
           r[17], (r[18] ? 12'hC00 : 12'(r[30:19])));
    end
    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule